// File: doc/BRIEF.md
# Launch-on-Shift Transition-Delay Test Sequencer

This block runs a two-vector transition-delay test on a small combinational network that sits between the cells of a mux-D scan chain. The chain and the network are inside the block. After a start request the sequencer holds scan enable high and loads the first vector through a serial input. It then gives one more shift clock, which turns the first vector into the second vector (V2), so that this last shift edge is the launch edge. Scan enable drops for exactly one functional edge, and on that edge the chain captures the network's response to the V1-to-V2 change. Scan enable then rises again, and the response is shifted out on the scan data output. On its way out the response is compared bit by bit with an expected response that was latched at start.

A tester or an on-chip test controller uses the block as follows. It pulses start, presents the vector bits serially, one per cycle, and then waits for a one-cycle done pulse. During that pulse the pass output gives the verdict. The chain length and the form of the combinational network are parameters. With `CUT_KIND = 0`, response bit k is `V2[k] ^ (V2[k+1] & ~V2[k+2])`. With `CUT_KIND = 1`, it is the XOR of the same three bits. In both forms the indices wrap modulo the chain length.

Top module: `shift_launch_seq`

## Requirements
- R1: While reset is asserted and in the first idle cycle after it, scan_en_o, done_o and pass_o are 0.
- R2: A start_i sampled high while idle makes scan_en_o 1 for exactly N+1 consecutive cycles, beginning in the cycle after that edge. On each of those edges scan_in_i enters chain bit 0, and every bit k moves to bit k+1.
- R3: The (N+1)-th shift edge is the launch edge. Serial bits b0..bN produce V1[k] = b(N-1-k) after N shifts and V2[k] = b(N-k) after the launch shift.
- R4: In the cycle after the launch edge, scan_en_o is 0 for exactly one cycle. That cycle's edge loads the chain with R = f(V2), where for CUT_KIND 0 R[k] = V2[k] ^ (V2[(k+1) mod N] & ~V2[(k+2) mod N]).
- R5: After capture, scan_en_o is 1 for exactly N cycles. In unload cycle j (counting from 0), scan_out_o shows R[N-1-j].
- R6: exp_resp_i is latched on the start edge, and later changes to it have no effect. exp_resp_i[k] is compared with R[k], and pass_o is 1 only if all N bits match.
- R7: done_o is 1 for exactly one cycle, 2N+3 edges after the start edge (counting the start edge as edge 0, done_o is seen after edge 2N+2). pass_o is 0 whenever done_o is 0.
- R8: start_i sampled while a test is in progress is ignored. The running test keeps its timing and its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, honoured only when idle |
| scan_in_i | input | 1 | Serial vector bit, sampled on shift edges |
| exp_resp_i | input | CHAIN_LEN | Expected response, latched at start |
| scan_en_o | output | 1 | Scan enable driven to the chain |
| scan_out_o | output | 1 | Serial data from the last chain cell |
| pass_o | output | 1 | Test passed, valid only with done_o |
| done_o | output | 1 | One-cycle end-of-test pulse |

## Verification
The bench builds the block with CHAIN_LEN = 4 and CUT_KIND = 0. At that size there are only 2^5 = 32 serial input sequences, so every combination of V1 and launched V2 can be swept. For each sequence the bench computes the response arithmetically and checks it bit by bit on the scan output. It runs every sequence once with the correct expected word and once with a corrupted one. A stray start is injected during capture on some runs, and the expected-response input is scrambled after the start edge, so that the ignore and latch rules are exercised throughout the sweep.

// File: rtl/shift_launch_pkg.sv
package shift_launch_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_SHIFT = 3'd1,
      ST_CAPT  = 3'd2,
      ST_UNLD  = 3'd3,
      ST_RPT   = 3'd4
   } seq_state_t;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/shift_launch_cell.sv
module shift_launch_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic shift_en,
   input  logic cap_en,
   input  logic si,
   input  logic d,
   output logic q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= 1'b0;
      else if (shift_en) q <= si;
      else if (cap_en)   q <= d;
   end

   AST_SHIFT_TAKES_SI: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> (q == $past(si)));                      // R2

   AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!shift_en && !cap_en) |=> $stable(q));              // R8

endmodule

// File: rtl/shift_launch_cut.sv
module shift_launch_cut #(
   parameter int unsigned CHAIN_LEN = 8,
   parameter int unsigned CUT_KIND  = 0
) (
   input  logic [CHAIN_LEN-1:0] v,
   output logic [CHAIN_LEN-1:0] r
);

   if (CUT_KIND > 1) begin : g_bad_kind
      $error("shift_launch_cut: CUT_KIND must be 0 or 1");
   end

   for (genvar k = 0; k < CHAIN_LEN; k++) begin : g_bit
      localparam int unsigned K1 = (k + 1) % CHAIN_LEN;
      localparam int unsigned K2 = (k + 2) % CHAIN_LEN;
      if (CUT_KIND == 0) begin : g_andmix
         assign r[k] = v[k] ^ (v[K1] & ~v[K2]);
      end else begin : g_xor3
         assign r[k] = v[k] ^ v[K1] ^ v[K2];
      end
   end

endmodule

// File: rtl/shift_launch_ctrl.sv
module shift_launch_ctrl
   import shift_launch_pkg::*;
#(
   parameter int unsigned CHAIN_LEN = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic shift_en,
   output logic cap_en,
   output logic cmp_en,
   output logic load_exp,
   output logic report
);

   localparam int unsigned CW = cnt_width(CHAIN_LEN);
   localparam logic [CW-1:0] LAST_SHIFT  = CW'(CHAIN_LEN);
   localparam logic [CW-1:0] LAST_UNLOAD = CW'(CHAIN_LEN - 1);

   seq_state_t      state_q, state_d;
   logic [CW-1:0]   cnt_q, cnt_d;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      unique case (state_q)
         ST_IDLE: begin
            cnt_d = '0;
            if (start_i) state_d = ST_SHIFT;
         end
         ST_SHIFT: begin
            if (cnt_q == LAST_SHIFT) begin
               state_d = ST_CAPT;
               cnt_d   = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         ST_CAPT: begin
            state_d = ST_UNLD;
            cnt_d   = '0;
         end
         ST_UNLD: begin
            if (cnt_q == LAST_UNLOAD) begin
               state_d = ST_RPT;
               cnt_d   = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         ST_RPT:  state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assign shift_en = (state_q == ST_SHIFT) || (state_q == ST_UNLD);
   assign cap_en   = (state_q == ST_CAPT);
   assign cmp_en   = (state_q == ST_UNLD);
   assign report   = (state_q == ST_RPT);
   assign load_exp = (state_q == ST_IDLE) && start_i;

   AST_CAPTURE_AFTER_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en |-> $past(shift_en));                          // R4

   AST_UNLOAD_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en |=> (shift_en && cmp_en));                     // R5

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      report |=> !report);                                  // R7

   AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && (shift_en || cap_en)) |=> (state_q != ST_IDLE)); // R8

endmodule

// File: rtl/shift_launch_cmp.sv
module shift_launch_cmp #(
   parameter int unsigned CHAIN_LEN = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load_exp,
   input  logic [CHAIN_LEN-1:0] exp_resp,
   input  logic                 cmp_en,
   input  logic                 so,
   output logic                 err
);

   logic [CHAIN_LEN-1:0] exp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_q <= '0;
         err   <= 1'b0;
      end else if (load_exp) begin
         exp_q <= exp_resp;
         err   <= 1'b0;
      end else if (cmp_en) begin
         exp_q <= {exp_q[CHAIN_LEN-2:0], 1'b0};
         err   <= err | (so ^ exp_q[CHAIN_LEN-1]);
      end
   end

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !load_exp) |=> err);                          // R6

   AST_ERR_CLEARS_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load_exp |=> !err);                                   // R6

endmodule

// File: rtl/shift_launch_seq.sv
module shift_launch_seq #(
   parameter int unsigned CHAIN_LEN = 8,
   parameter int unsigned CUT_KIND  = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic                 scan_in_i,
   input  logic [CHAIN_LEN-1:0] exp_resp_i,
   output logic                 scan_en_o,
   output logic                 scan_out_o,
   output logic                 pass_o,
   output logic                 done_o
);

   localparam int unsigned MSB = CHAIN_LEN - 1;

   if (CHAIN_LEN < 3) begin : g_bad_len
      $error("shift_launch_seq: CHAIN_LEN must be at least 3");
   end

   logic                 shift_en, cap_en, cmp_en, load_exp, report, err;
   logic [CHAIN_LEN-1:0] chain_q;
   logic [CHAIN_LEN-1:0] resp;

   shift_launch_ctrl #(.CHAIN_LEN(CHAIN_LEN)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .shift_en (shift_en),
      .cap_en   (cap_en),
      .cmp_en   (cmp_en),
      .load_exp (load_exp),
      .report   (report)
   );

   shift_launch_cut #(.CHAIN_LEN(CHAIN_LEN), .CUT_KIND(CUT_KIND)) u_cut (
      .v (chain_q),
      .r (resp)
   );

   for (genvar k = 0; k < CHAIN_LEN; k++) begin : g_cell
      logic si;
      if (k == 0) begin : g_head
         assign si = scan_in_i;
      end else begin : g_body
         assign si = chain_q[k-1];
      end
      shift_launch_cell u_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .shift_en (shift_en),
         .cap_en   (cap_en),
         .si       (si),
         .d        (resp[k]),
         .q        (chain_q[k])
      );
   end

   shift_launch_cmp #(.CHAIN_LEN(CHAIN_LEN)) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_exp (load_exp),
      .exp_resp (exp_resp_i),
      .cmp_en   (cmp_en),
      .so       (chain_q[MSB]),
      .err      (err)
   );

   assign scan_en_o  = shift_en;
   assign scan_out_o = chain_q[MSB];
   assign done_o     = report;
   assign pass_o     = report & ~err;

   AST_PASS_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      pass_o |-> done_o);                                   // R7

   AST_SE_LOW_AT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en |-> !scan_en_o);                               // R4

endmodule

// File: tb/tb_shift_launch_seq.sv
module tb_shift_launch_seq;

   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic         scan_in_i = 1'b0;
   logic [N-1:0] exp_resp_i = '0;
   logic         scan_en_o, scan_out_o, pass_o, done_o;

   int n_run  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   shift_launch_seq #(.CHAIN_LEN(N), .CUT_KIND(0)) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .scan_in_i  (scan_in_i),
      .exp_resp_i (exp_resp_i),
      .scan_en_o  (scan_en_o),
      .scan_out_o (scan_out_o),
      .pass_o     (pass_o),
      .done_o     (done_o)
   );

   task automatic chk(input logic ok, input string req, input int act, input int expv);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
      end
   endtask

   function automatic logic [N-1:0] resp_of(input logic [N:0] seq);
      logic [N-1:0] v2, r;
      for (int k = 0; k < N; k++) v2[k] = seq[N-k];            // R3
      for (int k = 0; k < N; k++)
         r[k] = v2[k] ^ (v2[(k+1)%N] & ~v2[(k+2)%N]);           // R4
      return r;
   endfunction

   task automatic run_test(input logic [N:0] seq, input logic [N-1:0] expw,
                           input logic want_pass, input logic stray_start);
      logic [N-1:0] r;
      r = resp_of(seq);
      @(negedge clk);
      start_i    = 1'b1;
      exp_resp_i = expw;
      @(posedge clk);                       // start edge E0
      @(negedge clk);
      start_i    = 1'b0;
      exp_resp_i = ~expw;                   // R6: late change must not matter
      for (int j = 0; j <= N; j++) begin
         scan_in_i = seq[j];
         chk(scan_en_o == 1'b1, "R2 shift scan_en", scan_en_o, 1);
         chk(done_o == 1'b0, "R7 done low in shift", done_o, 0);
         @(posedge clk);
         @(negedge clk);
      end
      chk(scan_en_o == 1'b0, "R4 scan_en low at capture", scan_en_o, 1'b0);
      if (stray_start) start_i = 1'b1;     // R8
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      for (int j = 0; j < N; j++) begin
         chk(scan_en_o == 1'b1, "R5 unload scan_en", scan_en_o, 1);
         chk(scan_out_o == r[N-1-j], "R3 R5 response bit", scan_out_o, r[N-1-j]);
         @(posedge clk);
         @(negedge clk);
      end
      chk(done_o == 1'b1, "R7 done at edge 2N+2", done_o, 1);
      chk(pass_o == want_pass, "R6 pass verdict", pass_o, want_pass);
      chk(scan_en_o == 1'b0, "R7 scan_en low at done", scan_en_o, 0);
      @(posedge clk);
      @(negedge clk);
      chk(done_o == 1'b0, "R7 done one cycle", done_o, 0);
      chk(pass_o == 1'b0, "R7 pass low without done", pass_o, 0);
      chk(scan_en_o == 1'b0, "R8 idle after stray start", scan_en_o, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(scan_en_o == 1'b0, "R1 reset scan_en", scan_en_o, 0);
      chk(done_o == 1'b0, "R1 reset done", done_o, 0);
      chk(pass_o == 1'b0, "R1 reset pass", pass_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(scan_en_o == 1'b0, "R1 idle scan_en", scan_en_o, 0);
      chk(done_o == 1'b0, "R1 idle done", done_o, 0);
      for (int s = 0; s < (1 << (N+1)); s++) begin
         logic [N:0]   seq;
         logic [N-1:0] good;
         seq  = (N+1)'(s);
         good = resp_of(seq);
         run_test(seq, good, 1'b1, s[0]);
         run_test(seq, good ^ (N'(1) << (s % N)), 1'b0, ~s[0]);
      end
      repeat (3) begin
         @(negedge clk);
         chk(scan_en_o == 1'b0 && done_o == 1'b0, "R8 stays idle", scan_en_o, 0);
      end
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule